// File: doc/BRIEF.md
# MFM Address Mark Detector

This block sits behind a floppy data separator. It takes the separator's window signal and the flux pulses that the window qualifies. Every change of the window level closes one encoded cell. The cells alternate between clock cells and data cells. The block shifts them through a 16-cell register and watches for a sync word that breaks the MFM clock rule. Because the pattern is illegal in MFM, the preamble and ordinary recorded data can never imitate it.

Once the required run of sync words has been seen back to back, the next byte is decoded and classified as an ID-record mark, a data mark or a deleted-data mark. The block then frames the fixed-length field that follows, payload plus CRC bytes, one byte strobe per byte. It flags the last byte and goes back to searching. A type byte it does not recognise drops the mark without reporting anything.

Top module: `mfm_addr_mark_det`

## Requirements
- R1: While reset is held, and after it is released with no cells arriving, `mark_o`, `byte_vld_o` and `done_o` stay low.
- R2: A cell ends at every change of `win_i`, rising or falling. The cell reads 1 if `rdd_i` was high in any clock after the change that opened it, up to and including the clock before the change that closes it. A pulse in the same clock as a window change belongs to the cell that is starting.
- R3: A sync word is the 16-cell pattern 0x4489, taking cells in arrival order from bit 15 down to bit 0. An A1 byte recorded with normal MFM clocking (0x44A9) never counts as sync.
- R4: A mark needs `SYNC_COUNT` sync words (3 by default), each exactly 16 cells after the previous one. With fewer sync words, or with a gap between them, no mark is reported.
- R5: The byte after the last sync word selects the mark: 0xFE gives `type_o` = 0 (ID), 0xFB gives 1 (data) and 0xF8 gives 2 (deleted data). `mark_o` pulses for one clock, with `type_o` valid in that clock.
- R6: Any other type byte produces no mark strobe and no byte strobes, and the search resumes at once, so a correct sector that follows is still found.
- R7: Field bytes take their bits from the second cell of each cell pair after the last sync word, MSB first. `byte_vld_o` is high for one clock per byte with `byte_o` valid, and `mark_o` and `byte_vld_o` are never high in the same clock.
- R8: An ID field is `ID_BYTES` + `CRC_BYTES` bytes (4 + 2 by default). A data or deleted-data field is `DATA_BYTES` + `CRC_BYTES` bytes.
- R9: `done_o` is high in the same clock as the strobe of the last field byte. The block then searches again, and the next sector is detected.
- R10: From `done_o` until the next mark strobe, no byte strobe is produced, whatever data keeps arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_i | input | 1 | Data window from the separator; each level change closes a cell |
| rdd_i | input | 1 | Qualified flux pulse, synchronous to clk |
| mark_o | output | 1 | One-clock strobe when a valid mark is classified |
| type_o | output | 2 | Mark type: 0 ID, 1 data, 2 deleted data |
| byte_o | output | 8 | Framed field byte |
| byte_vld_o | output | 1 | One-clock strobe for each field byte |
| done_o | output | 1 | High with the last byte of the field |

## Verification
The assertions assume that `win_i` and `rdd_i` are already synchronous to `clk` and that each cell lasts at least two clocks. Under that assumption, strobes from consecutive bytes can never fall in adjacent clocks. They also assume that the data between a mark and the end of its field is legal MFM, so no stray sync word appears inside a field. The stimulus keeps to these limits. It uses four-clock cells with a single one-clock pulse per cell, and it encodes every preamble, field and gap byte with proper MFM clocking. Only the sync words deliberately break the clock rule.

// File: rtl/mfm_am_pkg.sv
package mfm_am_pkg;
   localparam logic [15:0] SYNC_WORD = 16'h4489;
   localparam logic [7:0]  CODE_ID   = 8'hFE;
   localparam logic [7:0]  CODE_DATA = 8'hFB;
   localparam logic [7:0]  CODE_DEL  = 8'hF8;

   typedef enum logic [1:0] {
      MK_ID   = 2'd0,
      MK_DATA = 2'd1,
      MK_DEL  = 2'd2
   } mark_e;

   typedef enum logic [1:0] {
      ST_SEARCH,
      ST_SYNC,
      ST_TYPE,
      ST_FIELD
   } am_state_e;
endpackage

// File: rtl/mfm_cell_sampler.sv
module mfm_cell_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic win_i,
   input  logic rdd_i,
   output logic cell_vld,
   output logic cell_bit
);
   logic win_q;
   logic seen;
   logic win_chg;

   assign win_chg = win_i ^ win_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q    <= 1'b0;
         seen     <= 1'b0;
         cell_vld <= 1'b0;
         cell_bit <= 1'b0;
      end else begin
         win_q    <= win_i;
         cell_vld <= win_chg;
         if (win_chg) begin
            cell_bit <= seen;
            seen     <= rdd_i;
         end else begin
            seen     <= seen | rdd_i;
         end
      end
   end
endmodule

// File: rtl/mfm_cell_shift.sv
module mfm_cell_shift #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cell_vld,
   input  logic             cell_bit,
   output logic             sr_vld,
   output logic [WIDTH-1:0] sr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr     <= '0;
         sr_vld <= 1'b0;
      end else begin
         sr_vld <= cell_vld;
         if (cell_vld) sr <= {sr[WIDTH-2:0], cell_bit};
      end
   end
endmodule

// File: rtl/mfm_am_fsm.sv
module mfm_am_fsm
   import mfm_am_pkg::*;
#(
   parameter int ID_BYTES   = 4,
   parameter int DATA_BYTES = 8,
   parameter int CRC_BYTES  = 2,
   parameter int SYNC_COUNT = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sr_vld,
   input  logic [15:0] sr,
   output logic        mark_o,
   output logic [1:0]  type_o,
   output logic [7:0]  byte_o,
   output logic        byte_vld_o,
   output logic        done_o
);
   localparam int MAX_LEN = ((ID_BYTES > DATA_BYTES) ? ID_BYTES : DATA_BYTES) + CRC_BYTES;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam int SC_W    = $clog2(SYNC_COUNT + 1);
   localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_BYTES + CRC_BYTES - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BYTES + CRC_BYTES - 1);
   localparam logic [SC_W-1:0]  SC_LAST   = SC_W'(SYNC_COUNT - 1);

   am_state_e        st;
   logic [3:0]       cell_cnt;
   logic [SC_W-1:0]  sync_cnt;
   logic [CNT_W-1:0] byte_cnt;
   logic [CNT_W-1:0] fld_last;
   mark_e            mk;
   logic [7:0]       dbyte;
   logic             slot_end;

   // data cells are the second of each pair: even positions of the shifter
   for (genvar g = 0; g < 8; g++) begin : g_dbit
      assign dbyte[g] = sr[2*g];
   end

   assign slot_end = (cell_cnt == 4'd15);
   assign type_o   = mk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_SEARCH;
         cell_cnt   <= '0;
         sync_cnt   <= '0;
         byte_cnt   <= '0;
         fld_last   <= '0;
         mk         <= MK_ID;
         byte_o     <= '0;
         mark_o     <= 1'b0;
         byte_vld_o <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         mark_o     <= 1'b0;
         byte_vld_o <= 1'b0;
         done_o     <= 1'b0;
         if (sr_vld) begin
            case (st)
               ST_SEARCH: begin
                  if (sr == SYNC_WORD) begin
                     cell_cnt <= '0;
                     sync_cnt <= SC_W'(1);
                     st       <= (SYNC_COUNT == 1) ? ST_TYPE : ST_SYNC;
                  end
               end
               ST_SYNC: begin
                  cell_cnt <= cell_cnt + 4'd1;
                  if (slot_end) begin
                     if (sr == SYNC_WORD) begin
                        sync_cnt <= sync_cnt + SC_W'(1);
                        if (sync_cnt == SC_LAST) st <= ST_TYPE;
                     end else begin
                        st <= ST_SEARCH;
                     end
                  end
               end
               ST_TYPE: begin
                  cell_cnt <= cell_cnt + 4'd1;
                  if (slot_end) begin
                     byte_cnt <= '0;
                     st       <= ST_FIELD;
                     case (dbyte)
                        CODE_ID: begin
                           mark_o <= 1'b1; mk <= MK_ID; fld_last <= ID_LAST;
                        end
                        CODE_DATA: begin
                           mark_o <= 1'b1; mk <= MK_DATA; fld_last <= DATA_LAST;
                        end
                        CODE_DEL: begin
                           mark_o <= 1'b1; mk <= MK_DEL; fld_last <= DATA_LAST;
                        end
                        default: st <= ST_SEARCH;
                     endcase
                  end
               end
               ST_FIELD: begin
                  cell_cnt <= cell_cnt + 4'd1;
                  if (slot_end) begin
                     byte_o     <= dbyte;
                     byte_vld_o <= 1'b1;
                     byte_cnt   <= byte_cnt + CNT_W'(1);
                     if (byte_cnt == fld_last) begin
                        done_o <= 1'b1;
                        st     <= ST_SEARCH;
                     end
                  end
               end
               default: st <= ST_SEARCH;
            endcase
         end
      end
   end
endmodule

// File: rtl/mfm_addr_mark_det.sv
module mfm_addr_mark_det #(
   parameter int ID_BYTES   = 4,
   parameter int DATA_BYTES = 8,
   parameter int CRC_BYTES  = 2,
   parameter int SYNC_COUNT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       win_i,
   input  logic       rdd_i,
   output logic       mark_o,
   output logic [1:0] type_o,
   output logic [7:0] byte_o,
   output logic       byte_vld_o,
   output logic       done_o
);
   localparam int CELLS = 16;

   if (CRC_BYTES < 1 || CRC_BYTES > 2) begin : g_bad_crc
      $error("CRC_BYTES must be 1 or 2");
   end
   if (ID_BYTES < 1 || DATA_BYTES < 1) begin : g_bad_len
      $error("field payload lengths must be positive");
   end
   if (SYNC_COUNT < 1 || SYNC_COUNT > 7) begin : g_bad_sync
      $error("SYNC_COUNT must be 1 to 7");
   end

   logic             cell_vld;
   logic             cell_bit;
   logic             sr_vld;
   logic [CELLS-1:0] sr;

   mfm_cell_sampler u_samp (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_i    (win_i),
      .rdd_i    (rdd_i),
      .cell_vld (cell_vld),
      .cell_bit (cell_bit)
   );

   mfm_cell_shift #(.WIDTH(CELLS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_vld (cell_vld),
      .cell_bit (cell_bit),
      .sr_vld   (sr_vld),
      .sr       (sr)
   );

   mfm_am_fsm #(
      .ID_BYTES   (ID_BYTES),
      .DATA_BYTES (DATA_BYTES),
      .CRC_BYTES  (CRC_BYTES),
      .SYNC_COUNT (SYNC_COUNT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sr_vld     (sr_vld),
      .sr         (sr),
      .mark_o     (mark_o),
      .type_o     (type_o),
      .byte_o     (byte_o),
      .byte_vld_o (byte_vld_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/mfm_am_chk.sv
module mfm_am_chk #(
   parameter int ID_BYTES   = 4,
   parameter int DATA_BYTES = 8,
   parameter int CRC_BYTES  = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mark_o,
   input logic [1:0] type_o,
   input logic       byte_vld_o,
   input logic       done_o
);
   logic        in_field;
   logic [15:0] seen_bytes;
   logic [15:0] exp_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_field   <= 1'b0;
         seen_bytes <= '0;
         exp_len    <= '0;
      end else begin
         if (mark_o) begin
            in_field   <= 1'b1;
            seen_bytes <= '0;
            exp_len    <= (type_o == 2'd0) ? 16'(ID_BYTES + CRC_BYTES)
                                           : 16'(DATA_BYTES + CRC_BYTES);
         end else if (byte_vld_o) begin
            seen_bytes <= seen_bytes + 16'd1;
         end
         if (done_o) in_field <= 1'b0;
      end
   end

   a_r5_mark_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |=> !mark_o);
   a_r5_type_code: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |-> (type_o != 2'd3));
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mark_o, byte_vld_o}));
   a_r7_byte_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);
   a_r9_done_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> byte_vld_o);
   a_r8_field_len: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (seen_bytes + 16'd1 == exp_len));
   a_r10_bytes_in_field: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> in_field);
   a_r6_mark_outside_field: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |-> !in_field);
endmodule

bind mfm_addr_mark_det mfm_am_chk #(
   .ID_BYTES   (ID_BYTES),
   .DATA_BYTES (DATA_BYTES),
   .CRC_BYTES  (CRC_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mark_o     (mark_o),
   .type_o     (type_o),
   .byte_vld_o (byte_vld_o),
   .done_o     (done_o)
);

// File: tb/sim_mfm_addr_mark_det.sv
`timescale 1ns/1ps
module sim_mfm_addr_mark_det;
   localparam int IDB = 4;
   localparam int DB  = 8;
   localparam int CB  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       win_i = 1'b0;
   logic       rdd_i = 1'b0;
   logic       mark_o;
   logic [1:0] type_o;
   logic [7:0] byte_o;
   logic       byte_vld_o;
   logic       done_o;

   int tests = 0;
   int fails = 0;

   int         mk_n, bt_n, dn_n, dn_bad, dn_pos;
   logic [1:0] last_type;
   logic [7:0] got [0:63];
   logic [7:0] expb [0:63];
   bit         prev_d;
   int         poff;

   always #5 clk = ~clk;

   mfm_addr_mark_det #(.ID_BYTES(IDB), .DATA_BYTES(DB), .CRC_BYTES(CB), .SYNC_COUNT(3)) u0 (
      .clk(clk), .rst_n(rst_n), .win_i(win_i), .rdd_i(rdd_i),
      .mark_o(mark_o), .type_o(type_o), .byte_o(byte_o),
      .byte_vld_o(byte_vld_o), .done_o(done_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (mark_o) begin mk_n++; last_type = type_o; end
         if (byte_vld_o) begin
            if (bt_n < 64) got[bt_n] = byte_o;
            bt_n++;
         end
         if (done_o) begin
            dn_n++;
            dn_pos = bt_n;
            if (!byte_vld_o) dn_bad++;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      mk_n = 0; bt_n = 0; dn_n = 0; dn_bad = 0; dn_pos = -1; last_type = 2'd3;
   endtask

   task automatic send_cell(input bit b);
      @(negedge clk);
      win_i = ~win_i;
      rdd_i = (poff == 0) ? b : 1'b0;
      for (int k = 1; k < 4; k++) begin
         @(negedge clk);
         rdd_i = (poff == k) ? b : 1'b0;
      end
   endtask

   task automatic send_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) send_cell(w[i]);
   endtask

   task automatic send_byte(input logic [7:0] v);
      logic [15:0] w;
      for (int j = 7; j >= 0; j--) begin
         w[2*j]   = v[j];
         w[2*j+1] = !prev_d && !v[j];
         prev_d   = v[j];
      end
      send_word(w);
   endtask

   task automatic sector(input int nsync, input bit legal_sync, input logic [7:0] tb_code,
                         input int nbytes, input int base, input int step);
      clear_mon();
      for (int i = 0; i < 12; i++) send_byte(8'h00);
      for (int i = 0; i < nsync; i++) begin
         if (legal_sync) send_byte(8'hA1);
         else begin send_word(16'h4489); prev_d = 1'b1; end
      end
      send_byte(tb_code);
      for (int k = 0; k < nbytes; k++) begin
         expb[k] = 8'((base + k * step) & 255);
         send_byte(expb[k]);
      end
      for (int i = 0; i < 4; i++) send_byte(8'h4E);
   endtask

   task automatic expect_field(input string req, input int typ, input int len);
      check({req, " mark count"}, mk_n, 1);
      check({req, " mark type"}, int'(last_type), typ);
      check({"R8 ", req, " byte count"}, bt_n, len);
      check({"R9 ", req, " done count"}, dn_n, 1);
      check({"R9 ", req, " done with last byte"}, dn_pos, len);
      check({"R9 ", req, " done without byte"}, dn_bad, 0);
      for (int k = 0; k < len && k < 64; k++)
         check({"R7 ", req, " byte value"}, int'(got[k]), int'(expb[k]));
   endtask

   task automatic expect_none(input string req);
      check({req, " no mark"}, mk_n, 0);
      check({req, " no bytes"}, bt_n, 0);
      check({req, " no done"}, dn_n, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      prev_d = 1'b0;
      poff = 2;
      clear_mon();
      repeat (4) @(negedge clk);
      check("R1 mark in reset", int'(mark_o), 0);
      check("R1 byte in reset", int'(byte_vld_o), 0);
      check("R1 done in reset", int'(done_o), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R1 idle after reset", mk_n + bt_n + dn_n, 0);

      // R5 R8: ID record, pulses mid-cell
      sector(3, 1'b0, 8'hFE, IDB + CB, 8'h10, 3);
      expect_field("R5 id", 0, IDB + CB);

      // R2: pulse in the clock right before the closing change
      poff = 3;
      sector(3, 1'b0, 8'hFB, DB + CB, 8'hA1, 7);
      expect_field("R2 R5 data late pulse", 1, DB + CB);

      // R2: pulse in the same clock as the opening change
      poff = 0;
      sector(3, 1'b0, 8'hF8, DB + CB, 8'hFE, 1);
      expect_field("R2 R5 deleted edge pulse", 2, DB + CB);
      poff = 1;

      // R6: unknown type byte, then a good sector right after
      sector(3, 1'b0, 8'hFC, DB + CB, 8'h55, 1);
      expect_none("R6 unknown type");
      sector(3, 1'b0, 8'hFE, IDB + CB, 8'h00, 1);
      expect_field("R6 R9 rearm", 0, IDB + CB);

      // R4: only two sync words
      sector(2, 1'b0, 8'hFE, IDB + CB, 8'h20, 1);
      expect_none("R4 two syncs");

      // R3: normally clocked A1 bytes are not sync
      sector(3, 1'b1, 8'hFE, IDB + CB, 8'h30, 1);
      expect_none("R3 legal A1");

      // R7 R10: every byte value through data fields, gap bytes not framed
      poff = 2;
      for (int s = 0; s < 32; s++) begin
         sector(3, 1'b0, 8'hFB, DB + CB, s * 8, 1);
         expect_field("R10 sweep", 1, DB + CB);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule